// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts a single 128-bit plaintext block under a 128-bit cipher key with the AES algorithm. The datapath is iterative and performs one cipher round per clock. The round key for each round is derived combinationally from the previous one, in the same cycle that the state passes through byte substitution, row shifting and column mixing. As a result, no expanded key schedule is ever stored.

A caller presents plaintext and key together with a one-cycle start strobe. After the start strobe is accepted, the block first XORs the plaintext with the cipher key. It then runs nine full rounds and one final round that skips column mixing. When the last round completes, the block raises a one-cycle done strobe with the ciphertext on its output. The ciphertext stays on the output until the next accepted start.

Top module: `aes128_iter_enc`

## Requirements
- R1: While rst_ni is low, and after reset until the first accepted start, done_o is 0 and cipher_o is all zeros.
- R2: Bytes are packed with byte 0 in bits [127:120] and byte 15 in bits [7:0]. The state is column-major: byte i sits in row i mod 4 and column i div 4. Under this packing, key 000102030405060708090a0b0c0d0e0f encrypts plaintext 00112233445566778899aabbccddeeff to 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: The ciphertext equals AES-128 applied to the captured plaintext and key. The sequence is an initial key XOR, then nine rounds of substitution, row shift (row r rotated left by r), column mix and key XOR, then a final round without column mix.
- R4: Each round key comes from the previous one. The last word is rotated left by one byte, each of its bytes is substituted, and its first byte is XORed with the round constant (01,02,04,08,10,20,40,80,1b,36 for rounds 1 to 10). That word is XORed into word 0, and each later word is XORed with the new word before it.
- R5: A start accepted at one clock edge makes done_o high during the 11th cycle, counting the cycle in which start_i is sampled as the first. done_o stays high for exactly one cycle.
- R6: While no start is accepted, cipher_o holds its value regardless of changes on plain_i and key_i.
- R7: A start_i pulse while an encryption is in progress is ignored: the running result and its timing are unchanged.
- R8: A start_i held high during the cycle in which done_o is high is accepted, so encryptions can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; plaintext and key are captured when idle |
| plain_i | input | 128 | Plaintext block, byte 0 in the top bits |
| key_i | input | 128 | Cipher key, byte 0 in the top bits |
| cipher_o | output | 128 | Ciphertext, valid from the done cycle until the next accepted start |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that start_i is a synchronous level sampled on the rising edge. They also assume that plain_i and key_i carry known values whenever a start can be accepted. Nothing is assumed about start_i while a run is in progress, because the latency and no-restart properties exist to cover that case. The bench drives every input on the falling edge. It uses known-answer vectors and a sweep of pseudo-random plaintext and key pairs checked against an arithmetic model. It also raises start in the middle of a run, changes the data inputs while the block is idle, and issues a start during the done cycle.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 32;
  localparam int BLK_W    = 128;
  localparam int N_BYTES  = BLK_W / BYTE_W;
  localparam int N_WORDS  = BLK_W / WORD_W;
  localparam int N_ROUNDS = 10;
  localparam int ROUND_W  = $clog2(N_ROUNDS + 1);

  typedef logic [BYTE_W-1:0] u8_t;

  function automatic u8_t xtime_f(u8_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic u8_t gmul_f(u8_t a, u8_t b);
    u8_t p = '0;
    u8_t x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime_f(x);
    end
    return p;
  endfunction

  // a^254 by repeated squaring; maps 0 to 0
  function automatic u8_t ginv_f(u8_t a);
    u8_t r  = 8'h01;
    u8_t sq = a;
    for (int i = 1; i < BYTE_W; i++) begin
      sq = gmul_f(sq, sq);
      r  = gmul_f(r, sq);
    end
    return r;
  endfunction

  function automatic u8_t affine_f(u8_t b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic u8_t sbox_f(u8_t a);
    return affine_f(ginv_f(a));
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_enc_pkg::*;
(
  input  u8_t a_i,
  output u8_t s_o
);
  assign s_o = sbox_f(a_i);
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  u8_t sin [N_BYTES];
  u8_t sub [N_BYTES];
  u8_t sh  [N_BYTES];
  u8_t mix [N_BYTES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_sub
    assign sin[i] = state_i[BLK_W-1-BYTE_W*i -: BYTE_W];
    aes_sbox i_sbox (.a_i(sin[i]), .s_o(sub[i]));
  end

  for (genvar c = 0; c < N_WORDS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sh[4*c+r] = sub[4*((c+r)%N_WORDS)+r];
    end
    u8_t a0, a1, a2, a3;
    assign a0 = sh[4*c];
    assign a1 = sh[4*c+1];
    assign a2 = sh[4*c+2];
    assign a3 = sh[4*c+3];
    assign mix[4*c]   = xtime_f(a0) ^ xtime_f(a1) ^ a1 ^ a2 ^ a3;
    assign mix[4*c+1] = a0 ^ xtime_f(a1) ^ xtime_f(a2) ^ a2 ^ a3;
    assign mix[4*c+2] = a0 ^ a1 ^ xtime_f(a2) ^ xtime_f(a3) ^ a3;
    assign mix[4*c+3] = xtime_f(a0) ^ a0 ^ a1 ^ a2 ^ xtime_f(a3);
  end

  for (genvar i = 0; i < N_BYTES; i++) begin : g_out
    assign state_o[BLK_W-1-BYTE_W*i -: BYTE_W] =
      (last_i ? sh[i] : mix[i]) ^ rkey_i[BLK_W-1-BYTE_W*i -: BYTE_W];
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] key_i,
  input  u8_t              rcon_i,
  output logic [BLK_W-1:0] key_o
);
  logic [WORD_W-1:0] w  [N_WORDS];
  logic [WORD_W-1:0] nw [N_WORDS];
  u8_t rot [4];
  u8_t sub [4];

  for (genvar j = 0; j < N_WORDS; j++) begin : g_w
    assign w[j] = key_i[BLK_W-1-WORD_W*j -: WORD_W];
    assign key_o[BLK_W-1-WORD_W*j -: WORD_W] = nw[j];
  end

  // last word, rotated left one byte
  for (genvar b = 0; b < 4; b++) begin : g_sb
    assign rot[b] = w[N_WORDS-1][WORD_W-1-BYTE_W*((b+1)%4) -: BYTE_W];
    aes_sbox i_sbox (.a_i(rot[b]), .s_o(sub[b]));
  end

  assign nw[0] = w[0] ^ {sub[0] ^ rcon_i, sub[1], sub[2], sub[3]};
  for (genvar j = 1; j < N_WORDS; j++) begin : g_chain
    assign nw[j] = w[j] ^ nw[j-1];
  end
endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl
  import aes_enc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               load_o,
  output logic               busy_o,
  output logic               last_o,
  output u8_t                rcon_o,
  output logic [ROUND_W-1:0] round_o,
  output logic               done_o
);
  localparam logic [ROUND_W-1:0] LAST_RND = ROUND_W'(N_ROUNDS);

  logic [ROUND_W-1:0] round_q;
  u8_t                rcon_q;
  logic               done_q;

  assign busy_o  = (round_q != '0);
  assign load_o  = start_i && !busy_o;
  assign last_o  = (round_q == LAST_RND);
  assign rcon_o  = rcon_q;
  assign round_o = round_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      round_q <= '0;
      rcon_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        round_q <= ROUND_W'(1);
        rcon_q  <= 8'h01;
      end else if (busy_o) begin
        rcon_q <= xtime_f(rcon_q);
        if (last_o) begin
          round_q <= '0;
          done_q  <= 1'b1;
        end else begin
          round_q <= round_q + ROUND_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes_enc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] plain_i,
  input  logic [BLK_W-1:0] key_i,
  output logic [BLK_W-1:0] cipher_o,
  output logic             done_o
);
  logic               load, busy, last;
  u8_t                rcon;
  logic [ROUND_W-1:0] round_cnt;
  logic [BLK_W-1:0]   state_q, rkey_q, next_key, round_out;

  aes_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .busy_o  (busy),
    .last_o  (last),
    .rcon_o  (rcon),
    .round_o (round_cnt),
    .done_o  (done_o)
  );

  aes_key_step i_key_step (
    .key_i  (rkey_q),
    .rcon_i (rcon),
    .key_o  (next_key)
  );

  aes_round i_round (
    .state_i (state_q),
    .rkey_i  (next_key),
    .last_i  (last),
    .state_o (round_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      rkey_q  <= '0;
    end else if (load) begin
      state_q <= plain_i ^ key_i;
      rkey_q  <= key_i;
    end else if (busy) begin
      state_q <= round_out;
      rkey_q  <= next_key;
    end
  end

  assign cipher_o = state_q;
endmodule

// File: rtl/aes128_iter_enc_chk.sv
module aes128_iter_enc_chk
  import aes_enc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               done_o,
  input logic [BLK_W-1:0]   cipher_o,
  input logic               busy_i,
  input logic [ROUND_W-1:0] round_i
);
  localparam logic [ROUND_W-1:0] LAST_RND = ROUND_W'(N_ROUNDS);
  localparam logic [ROUND_W:0]   DONE_CNT = (ROUND_W+1)'(N_ROUNDS + 1);

  logic [ROUND_W:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i && !busy_i) cnt_q <= (ROUND_W+1)'(1);
    else if (cnt_q != '0 && cnt_q != DONE_CNT) cnt_q <= cnt_q + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> (!done_o && cipher_o == '0));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q == DONE_CNT));

  p_done_due_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == DONE_CNT - 1'b1) |=> done_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(cipher_o));

  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && round_i != LAST_RND) |=> (busy_i && round_i == $past(round_i) + 1'b1));

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);
endmodule

bind aes128_iter_enc aes128_iter_enc_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_o   (done_o),
  .cipher_o (cipher_o),
  .busy_i   (busy),
  .round_i  (round_cnt)
);

// File: tb/test_aes128_iter_enc.sv
module test_aes128_iter_enc;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;
  localparam int N_SWEEP    = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plain = '0;
  logic [127:0] key = '0;
  logic [127:0] cipher;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [7:0] sb [256];

  aes128_iter_enc i_aes128_iter_enc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .plain_i(plain), .key_i(key), .cipher_o(cipher), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG_CYC) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WDOG_CYC);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) p ^= a;
      a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
      b = b >> 1;
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_enc(logic [127:0] pt, logic [127:0] k128);
    logic [7:0] s[16], k[16], n[16], t[4];
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      s[i] = pt[127-8*i -: 8];
      k[i] = k128[127-8*i -: 8];
      s[i] ^= k[i];
    end
    for (int r = 1; r <= 10; r++) begin
      t[0] = sb[k[13]] ^ rc; t[1] = sb[k[14]]; t[2] = sb[k[15]]; t[3] = sb[k[12]];
      for (int i = 0; i < 4; i++) k[i] ^= t[i];
      for (int i = 4; i < 16; i++) k[i] ^= k[i-4];
      rc = bmul(rc, 8'h02);
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int rw = 0; rw < 4; rw++) n[4*c+rw] = s[4*((c+rw)%4)+rw];
      for (int c = 0; c < 4; c++)
        for (int rw = 0; rw < 4; rw++)
          s[4*c+rw] = (r == 10) ? n[4*c+rw] :
            bmul(n[4*c+rw], 8'h02) ^ bmul(n[4*c+(rw+1)%4], 8'h03)
            ^ n[4*c+(rw+2)%4] ^ n[4*c+(rw+3)%4];
      for (int i = 0; i < 16; i++) s[i] ^= k[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic [127:0] pt, input logic [127:0] k);
    @(negedge clk);
    start = 1'b1; plain = pt; key = k;
    @(negedge clk);
    start = 1'b0;
  endtask

  // lat counts negedges after the accepting edge, starting at 1
  task automatic wait_done(inout int lat);
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(input string tag, input logic [127:0] pt,
                         input logic [127:0] k, input logic [127:0] exp);
    int lat = 1;
    start_op(pt, k);
    wait_done(lat);
    chk({tag, " R5 latency"}, 128'(lat), 128'd11);
    chk(tag, cipher, exp);
    @(negedge clk);
    chk("R5 done single pulse", 128'(done), 128'd0);
  endtask

  initial begin
    logic [127:0] pt, k, exp;
    int lat;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      logic [7:0] o;
      for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
               ^ (8'h63 >> i) & 8'h01;
      sb[x] = o;
    end

    repeat (3) @(negedge clk);
    chk("R1 reset done", 128'(done), 128'd0);
    chk("R1 reset cipher", cipher, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {127'(cipher != '0), done}, 128'd0);

    run_one("R2 kat1", 128'h00112233445566778899aabbccddeeff,
            128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_one("R2 kat2", 128'h3243f6a8885a308d313198a2e0370734,
            128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32);
    run_one("R4 zero key", '0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    run_one("R4 ones key", '1, '1, ref_enc('1, '1));

    for (int v = 0; v < N_SWEEP; v++) begin
      pt = {$urandom, $urandom, $urandom, $urandom};
      k  = (v % 4 == 0) ? {4{$urandom}} : {$urandom, $urandom, $urandom, $urandom};
      run_one("R3 R4 sweep", pt, k, ref_enc(pt, k));
    end

    // R6: data inputs change while idle, output holds
    exp = cipher;
    @(negedge clk);
    plain = ~plain; key = ~key;
    repeat (4) @(negedge clk);
    chk("R6 hold idle", cipher, exp);

    // R7: second start mid-run is ignored
    pt = 128'h0123456789abcdeffedcba9876543210;
    k  = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    lat = 1;
    start_op(pt, k);
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b1; plain = '1; key = '0;
    @(negedge clk); lat++;
    start = 1'b0;
    wait_done(lat);
    chk("R7 latency unchanged", 128'(lat), 128'd11);
    chk("R7 result unchanged", cipher, ref_enc(pt, k));

    // R8: start during the done cycle
    pt = 128'hdeadbeef00000000cafef00d12345678;
    k  = 128'h00000000000000000000000000000001;
    start = 1'b1; plain = pt; key = k;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done dropped", 128'(done), 128'd0);
    lat = 1;
    wait_done(lat);
    chk("R8 b2b latency", 128'(lat), 128'd11);
    chk("R8 b2b result", cipher, ref_enc(pt, k));
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule